// File: doc/BRIEF.md
# Configuration Space Access Engine

This block sits between a local requester and a simplified host-bridge port and carries out configuration reads and writes of 1, 2 or 4 bytes. Each accepted request becomes one or two 32-bit configuration cycles. For each cycle the engine builds an address word that carries an enable flag, the bus number, the device/function field and the dword-aligned register offset. It clears the bridge's error status and raises a cycle request. When the port acknowledges, it samples the status vector to decide whether the cycle succeeded.

Reads deliver the addressed byte or halfword right-justified. Byte and halfword writes are carried out as a read of the containing dword, a merge of the new lane, and a write-back of the whole dword. Misaligned halfword and dword offsets are refused with a bad-register code and reach no bus cycle. An unsupported size is refused with a failure code. A failed or refused read returns all ones. The requester holds off until the single-cycle `done` pulse, which carries a result code: 0 success, 1 bad register, 2 access failure.

The controller has five states. IDLE accepts a request. It goes to CLEAR when the request is valid, and straight to DONE when the request is refused. CLEAR pulses the status clear with the address already presented, then goes to ISSUE. ISSUE holds the cycle request until acknowledge, then goes to RELEASE. RELEASE drops the address word to zero. From RELEASE, a clean read phase of a read-modify-write returns to CLEAR for the write-back. Every other outcome goes to DONE. DONE pulses `done` and returns to IDLE.

Top module: `cfg_access_engine`

## Requirements
- R1: While a cycle request is raised, `cyc_addr` holds bit 31 = 1, bits [23:16] = bus number, bits [15:8] = device/function, bits [7:2] = offset[7:2] and bits [1:0] = 0. In the cycle after an acknowledge it is zero, and it is zero after reset.
- R2: `cyc_type1` is 1 during a cycle exactly when the bus number is non-zero.
- R3: `stat_clr` pulses for one cycle directly before every cycle request. It tells the bridge to clear all status bits except the reserved ones (bits 9:8 by default), so stale error bits do not fail the next access.
- R4: An access fails (code 2) when any non-reserved bit of `err_status` is set at acknowledge. Reserved bits alone never cause a failure.
- R5: A byte read returns the dword shifted right by 8 × offset[1:0], masked to 8 bits. A halfword read uses the same shift with a 16-bit mask. A dword read returns the dword unchanged.
- R6: A halfword request with offset[1:0] = 3, or a dword request with offset[1:0] ≠ 0, ends with code 1 and issues no bus cycle.
- R7: A byte or halfword write issues a read cycle and then a write cycle carrying the merged dword. A failure in the read phase ends the request with code 2 and no write cycle.
- R8: A failed or refused read returns 0xFFFFFFFF. A size other than 1, 2 or 4 ends with code 2 and no bus cycle. Writes return 0 in `done_rdata`.
- R9: Write data is little-endian: the byte at offset base+k travels on `cyc_wdata[8k+7:8k]`. A dword write presents the requester's word unchanged.
- R10: Each request yields exactly one `done` pulse, one clock long. After reset `done`, `cyc_req` and `stat_clr` are 0.
- R11: The device/function field is forwarded unchanged for every value, including device numbers below 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle, only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function field |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write value, right-justified |
| done | output | 1 | Request complete, one-cycle pulse |
| done_err | output | 2 | Result: 0 ok, 1 bad register, 2 failure |
| done_rdata | output | 32 | Read result |
| stat_clr | output | 1 | Clear non-reserved status bits |
| cyc_req | output | 1 | Configuration cycle request |
| cyc_write | output | 1 | Cycle is a write |
| cyc_addr | output | 32 | Configuration address word |
| cyc_type1 | output | 1 | Type 1 access flag |
| cyc_wdata | output | 32 | Write dword for the cycle |
| cyc_ack | input | 1 | Cycle acknowledge |
| cyc_rdata | input | 32 | Read dword, valid with acknowledge |
| err_status | input | 32 | Bridge error status vector |

## Verification
The hardest case to reach is a read-modify-write whose read phase succeeds and whose write-back aborts. The target must answer the first cycle cleanly and fail the second. The bench model of the target has a switch that aborts only write cycles. With that switch set, the bench counts the bus cycles of the sub-dword write, expects a failure code, and reads the dword back to show it is unchanged. A separate case plants a stale error bit in the modelled status register before a read, to show that the clear pulse removes it before the cycle starts.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
    typedef enum logic [1:0] {
        CFG_OK     = 2'd0,
        CFG_BADREG = 2'd1,
        CFG_FAIL   = 2'd2
    } cfg_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ISSUE,
        ST_RELEASE,
        ST_DONE
    } cfg_state_e;
endpackage

// File: rtl/cfg_addr_build.sv
`timescale 1ns/1ps
module cfg_addr_build #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 8,
    parameter int DF_W   = 8,
    parameter int OFF_W  = 8
) (
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [DF_W-1:0]   devfn,
    input  logic [OFF_W-3:0]  off_hi,
    output logic [ADDR_W-1:0] addr_word,
    output logic              type1
);
    localparam int PAD_W = ADDR_W - 1 - BUS_W - DF_W - OFF_W;

    // enable | pad | bus | devfn | dword offset | two zero bits
    assign addr_word = {1'b1, {PAD_W{1'b0}}, bus_num, devfn, off_hi, 2'b00};
    assign type1     = (bus_num != '0);
endmodule

// File: rtl/cfg_lane_unit.sv
`timescale 1ns/1ps
module cfg_lane_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]          dword,
    input  logic [DW-1:0]          wval,
    input  logic [$clog2(DW/8)-1:0] lane,
    input  logic [2:0]             size,
    output logic [DW-1:0]          rd_lane,
    output logic [DW-1:0]          merged
);
    localparam int LANE_W = $clog2(DW/8);
    localparam int SH_W   = LANE_W + 3;

    logic [SH_W-1:0] shamt;
    logic [DW-1:0]   mask;

    assign shamt = {lane, 3'b000};

    always_comb begin
        unique case (size)
            3'd1:    mask = DW'(8'hFF);
            3'd2:    mask = DW'(16'hFFFF);
            default: mask = '1;
        endcase
    end

    assign rd_lane = (dword >> shamt) & mask;
    assign merged  = (dword & ~(mask << shamt)) | ((wval & mask) << shamt);
endmodule

// File: rtl/cfg_req_check.sv
`timescale 1ns/1ps
module cfg_req_check #(
    parameter int LANE_W = 2
) (
    input  logic [2:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic              size_ok,
    output logic              align_ok
);
    assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

    always_comb begin
        unique case (size)
            3'd2:    align_ok = (lane != '1);
            3'd4:    align_ok = (lane == '0);
            default: align_ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfg_access_engine.sv
`timescale 1ns/1ps
module cfg_access_engine
    import cfg_pkg::*;
#(
    parameter int              DW       = 32,
    parameter int              BUS_W    = 8,
    parameter int              DF_W     = 8,
    parameter int              OFF_W    = 8,
    parameter int              STAT_W   = 32,
    parameter logic [STAT_W-1:0] RSV_MASK = 32'h0000_0300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DF_W-1:0]   req_devfn,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DW-1:0]     req_wdata,
    output logic              done,
    output logic [1:0]        done_err,
    output logic [DW-1:0]     done_rdata,
    output logic              stat_clr,
    output logic              cyc_req,
    output logic              cyc_write,
    output logic [31:0]       cyc_addr,
    output logic              cyc_type1,
    output logic [DW-1:0]     cyc_wdata,
    input  logic              cyc_ack,
    input  logic [DW-1:0]     cyc_rdata,
    input  logic [STAT_W-1:0] err_status
);
    localparam int LANE_W = $clog2(DW/8);

    cfg_state_e       state, state_nx;
    logic [BUS_W-1:0] bus_q;
    logic [DF_W-1:0]  devfn_q;
    logic [OFF_W-1:0] off_q;
    logic [2:0]       size_q;
    logic             wr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    data_q;
    logic             phase_wr_q;
    logic             rmw_q;
    logic             fail_q;
    cfg_err_e         err_q;
    logic [DW-1:0]    rdout_q;

    logic             size_ok, align_ok;
    logic [31:0]      addr_word;
    logic             type1;
    logic [DW-1:0]    lane_rd, lane_merged;

    cfg_req_check #(.LANE_W(LANE_W)) u_check (
        .size     (req_size),
        .lane     (req_offset[LANE_W-1:0]),
        .size_ok  (size_ok),
        .align_ok (align_ok)
    );

    cfg_addr_build #(.ADDR_W(32), .BUS_W(BUS_W), .DF_W(DF_W), .OFF_W(OFF_W)) u_addr (
        .bus_num   (bus_q),
        .devfn     (devfn_q),
        .off_hi    (off_q[OFF_W-1:2]),
        .addr_word (addr_word),
        .type1     (type1)
    );

    cfg_lane_unit #(.DW(DW)) u_lane (
        .dword   (data_q),
        .wval    (wdata_q),
        .lane    (off_q[LANE_W-1:0]),
        .size    (size_q),
        .rd_lane (lane_rd),
        .merged  (lane_merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = (size_ok && align_ok) ? ST_CLEAR : ST_DONE;
            ST_CLEAR:   state_nx = ST_ISSUE;
            ST_ISSUE:   if (cyc_ack) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = (!fail_q && rmw_q && !phase_wr_q) ? ST_CLEAR : ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // request context and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q      <= '0;
            devfn_q    <= '0;
            off_q      <= '0;
            size_q     <= '0;
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            data_q     <= '0;
            phase_wr_q <= 1'b0;
            rmw_q      <= 1'b0;
            fail_q     <= 1'b0;
            err_q      <= CFG_OK;
            rdout_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    bus_q   <= req_bus;
                    devfn_q <= req_devfn;
                    off_q   <= req_offset;
                    size_q  <= req_size;
                    wr_q    <= req_write;
                    wdata_q <= req_wdata;
                    data_q  <= req_wdata;
                    fail_q  <= 1'b0;
                    if (!size_ok) begin
                        err_q   <= CFG_FAIL;
                        rdout_q <= req_write ? '0 : '1;
                    end else if (!align_ok) begin
                        err_q   <= CFG_BADREG;
                        rdout_q <= req_write ? '0 : '1;
                    end else begin
                        err_q      <= CFG_OK;
                        rdout_q    <= '0;
                        phase_wr_q <= req_write && (req_size == 3'd4);
                        rmw_q      <= req_write && (req_size != 3'd4);
                    end
                end
                ST_ISSUE: if (cyc_ack) begin
                    if (!phase_wr_q) data_q <= cyc_rdata;
                    fail_q <= |(err_status & ~RSV_MASK);
                end
                ST_RELEASE: begin
                    if (fail_q) begin
                        err_q   <= CFG_FAIL;
                        rdout_q <= wr_q ? '0 : '1;
                    end else if (rmw_q && !phase_wr_q) begin
                        data_q     <= lane_merged;
                        phase_wr_q <= 1'b1;
                    end else begin
                        err_q   <= CFG_OK;
                        rdout_q <= wr_q ? '0 : lane_rd;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        stat_clr   = (state == ST_CLEAR);
        cyc_req    = (state == ST_ISSUE);
        cyc_write  = (state == ST_ISSUE) && phase_wr_q;
        cyc_addr   = (state == ST_CLEAR || state == ST_ISSUE) ? addr_word : '0;
        cyc_type1  = (state == ST_CLEAR || state == ST_ISSUE) && type1;
        cyc_wdata  = ((state == ST_ISSUE) && phase_wr_q) ? data_q : '0;
        done       = (state == ST_DONE);
        done_err   = err_q;
        done_rdata = rdout_q;
    end
endmodule

// File: rtl/cfg_access_engine_chk.sv
`timescale 1ns/1ps
module cfg_access_engine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          stat_clr,
    input logic          cyc_req,
    input logic          cyc_write,
    input logic [31:0]   cyc_addr,
    input logic          cyc_type1,
    input logic          cyc_ack
);
    p_addr_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |-> (cyc_addr[31] && cyc_addr[1:0] == 2'b00));

    p_addr_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && cyc_ack) |=> (cyc_addr == 32'd0));

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_ack) |=> (cyc_req && $stable(cyc_addr) && $stable(cyc_write)));

    p_type1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |-> (cyc_type1 == (cyc_addr[23:16] != 8'd0)));

    p_clr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_req) |-> $past(stat_clr));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cyc_req && !stat_clr));
endmodule

bind cfg_access_engine cfg_access_engine_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .stat_clr  (stat_clr),
    .cyc_req   (cyc_req),
    .cyc_write (cyc_write),
    .cyc_addr  (cyc_addr),
    .cyc_type1 (cyc_type1),
    .cyc_ack   (cyc_ack)
);

// File: tb/cfg_access_engine_tb.sv
`timescale 1ns/1ps
module cfg_access_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd0;
    logic [7:0]  req_bus = 8'd0;
    logic [7:0]  req_devfn = 8'd0;
    logic [7:0]  req_offset = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        done;
    logic [1:0]  done_err;
    logic [31:0] done_rdata;
    logic        stat_clr;
    logic        cyc_req;
    logic        cyc_write;
    logic [31:0] cyc_addr;
    logic        cyc_type1;
    logic [31:0] cyc_wdata;
    logic        cyc_ack = 1'b0;
    logic [31:0] cyc_rdata = 32'd0;
    logic [31:0] err_status;

    always #2 clk = ~clk;

    cfg_access_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
        .req_wdata(req_wdata),
        .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .stat_clr(stat_clr), .cyc_req(cyc_req), .cyc_write(cyc_write),
        .cyc_addr(cyc_addr), .cyc_type1(cyc_type1), .cyc_wdata(cyc_wdata),
        .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata), .err_status(err_status)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // ---------------- target / bridge model ----------------
    localparam logic [31:0] RSV = 32'h0000_0300;
    logic [31:0] tgt_mem [16];
    logic [31:0] stat_reg = 32'd0;
    bit          abort_wr = 0;
    bit          inject_rsv = 0;
    int          cyc_cnt = 0;
    int          lat = 0;
    logic [31:0] last_addr = 0;
    logic        last_type1 = 0;
    logic [31:0] last_wdata = 0;
    logic        last_write = 0;

    assign err_status = stat_reg;

    initial begin
        forever begin
            @(negedge clk);
            if (stat_clr) stat_reg = stat_reg & RSV;
            if (cyc_ack) begin
                cyc_ack = 1'b0;
                lat = 0;
            end else if (cyc_req) begin
                lat++;
                if (lat == 2) begin
                    bit abrt;
                    abrt = (cyc_addr[15:8] == 8'hFF) || (cyc_write && abort_wr);
                    cyc_cnt++;
                    last_addr  = cyc_addr;
                    last_type1 = cyc_type1;
                    last_write = cyc_write;
                    last_wdata = cyc_wdata;
                    cyc_rdata  = tgt_mem[cyc_addr[5:2]];
                    if (abrt) stat_reg = stat_reg | 32'h0000_0020;
                    else if (cyc_write) tgt_mem[cyc_addr[5:2]] = cyc_wdata;
                    if (inject_rsv) stat_reg = stat_reg | 32'h0000_0100;
                    cyc_ack = 1'b1;
                end
            end else lat = 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0]  err;
        logic [31:0] rd;
        string       tag;
    } exp_t;
    exp_t        sb_q[$];
    logic [31:0] shadow [16];

    task automatic do_req(input bit wr, input logic [2:0] sz, input logic [7:0] bus,
                          input logic [7:0] df, input logic [7:0] off,
                          input logic [31:0] wd, input string tag);
        exp_t e;
        int   idx;
        int   ln;
        bit   sz_ok, al_ok, dead;
        idx   = int'(off[5:2]);
        ln    = int'(off[1:0]);
        sz_ok = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
        al_ok = (sz == 3'd1) || (sz == 3'd2 && ln != 3) || (sz == 3'd4 && ln == 0);
        dead  = (df == 8'hFF);
        e.tag = tag;
        if (!sz_ok) begin
            e.err = 2'd2; e.rd = wr ? 32'd0 : 32'hFFFF_FFFF;
        end else if (!al_ok) begin
            e.err = 2'd1; e.rd = wr ? 32'd0 : 32'hFFFF_FFFF;
        end else if (!wr) begin
            if (dead) begin
                e.err = 2'd2; e.rd = 32'hFFFF_FFFF;
            end else begin
                e.err = 2'd0;
                case (sz)
                    3'd1:    e.rd = {24'd0, shadow[idx][ln*8 +: 8]};
                    3'd2:    e.rd = {16'd0, shadow[idx][ln*8 +: 16]};
                    default: e.rd = shadow[idx];
                endcase
            end
        end else begin
            e.rd = 32'd0;
            if (dead || abort_wr) e.err = 2'd2;
            else begin
                e.err = 2'd0;
                case (sz)
                    3'd1:    shadow[idx][ln*8 +: 8]  = wd[7:0];
                    3'd2:    shadow[idx][ln*8 +: 16] = wd[15:0];
                    default: shadow[idx] = wd;
                endcase
            end
        end
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_bus = bus;
        req_devfn = df; req_offset = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        wait (done);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (done) begin
                if (sb_q.size() == 0) check(1'b0, "R10 unexpected done", {30'd0, done_err}, 32'd0);
                else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(done_err == e.err, {e.tag, " code"}, {30'd0, done_err}, {30'd0, e.err});
                    check(done_rdata == e.rd, {e.tag, " data"}, done_rdata, e.rd);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int c0;
        for (int i = 0; i < 16; i++) begin
            tgt_mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
            shadow[i]  = tgt_mem[i];
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!done && !cyc_req && !stat_clr, "R10 reset outputs", {29'd0, done, cyc_req, stat_clr}, 32'd0);
        check(cyc_addr == 32'd0, "R1 reset address", cyc_addr, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 dword read, bus 0, device 1 (below 10) R11
        do_req(0, 3'd4, 8'h00, 8'h08, 8'h10, 0, "R5 dword read");
        check(last_addr == 32'h8000_0810, "R1 R11 address word", last_addr, 32'h8000_0810);
        check(last_type1 == 1'b0, "R2 type0 on bus 0", {31'd0, last_type1}, 32'd0);

        // R5 byte read lane 3 on bus 3
        do_req(0, 3'd1, 8'h03, 8'h08, 8'h13, 0, "R5 byte read lane3");
        check(last_addr == 32'h8003_0810, "R1 offset low bits forced", last_addr, 32'h8003_0810);
        check(last_type1 == 1'b1, "R2 type1 on bus 3", {31'd0, last_type1}, 32'd1);
        do_req(0, 3'd2, 8'h00, 8'h3A, 8'h12, 0, "R5 half read lane2");
        do_req(0, 3'd2, 8'h00, 8'h3A, 8'h11, 0, "R5 half read lane1");

        // R6 alignment rejection, no cycle
        c0 = cyc_cnt;
        do_req(0, 3'd2, 8'h00, 8'h08, 8'h13, 0, "R6 half lane3 read");
        do_req(0, 3'd4, 8'h00, 8'h08, 8'h12, 0, "R6 dword misaligned read");
        do_req(1, 3'd4, 8'h00, 8'h08, 8'h01, 32'h1234_5678, "R6 dword misaligned write");
        // R8 illegal sizes
        do_req(0, 3'd3, 8'h00, 8'h08, 8'h00, 0, "R8 size3 read");
        do_req(1, 3'd0, 8'h00, 8'h08, 8'h00, 32'h1, "R8 size0 write");
        check(cyc_cnt == c0, "R6 R8 no bus cycle", cyc_cnt, c0);

        // R9 dword write passes through
        c0 = cyc_cnt;
        do_req(1, 3'd4, 8'h00, 8'h10, 8'h20, 32'h1122_3344, "R9 dword write");
        check(cyc_cnt == c0 + 1, "R7 dword write one cycle", cyc_cnt, c0 + 1);
        check(last_wdata == 32'h1122_3344, "R9 dword lanes", last_wdata, 32'h1122_3344);

        // R7 R9 byte RMW
        c0 = cyc_cnt;
        do_req(1, 3'd1, 8'h00, 8'h10, 8'h21, 32'h0000_00AB, "R7 byte write");
        check(cyc_cnt == c0 + 2, "R7 byte write two cycles", cyc_cnt, c0 + 2);
        check(last_write && last_wdata == 32'h1122_AB44, "R9 byte lane merge", last_wdata, 32'h1122_AB44);
        do_req(1, 3'd2, 8'h00, 8'h10, 8'h22, 32'h0000_BEEF, "R7 half write");
        check(last_wdata == 32'hBEEF_AB44, "R9 half lane merge", last_wdata, 32'hBEEF_AB44);
        do_req(0, 3'd4, 8'h00, 8'h10, 8'h20, 0, "R7 readback");

        // R4 R8 master abort on read
        do_req(0, 3'd2, 8'h01, 8'hFF, 8'h04, 0, "R4 R8 aborted read");
        // R7 abort in read phase: no write-back
        c0 = cyc_cnt;
        do_req(1, 3'd1, 8'h00, 8'hFF, 8'h05, 32'h55, "R7 read phase abort");
        check(cyc_cnt == c0 + 1, "R7 no write after read abort", cyc_cnt, c0 + 1);

        // R7 abort in write phase
        abort_wr = 1;
        c0 = cyc_cnt;
        do_req(1, 3'd2, 8'h00, 8'h10, 8'h20, 32'h0000_7777, "R7 write phase abort");
        check(cyc_cnt == c0 + 2, "R7 write phase reached", cyc_cnt, c0 + 2);
        abort_wr = 0;
        do_req(0, 3'd4, 8'h00, 8'h10, 8'h20, 0, "R7 unchanged after abort");

        // R4 reserved bits ignored
        inject_rsv = 1;
        do_req(0, 3'd1, 8'h00, 8'h20, 8'h30, 0, "R4 reserved bit read");
        inject_rsv = 0;

        // R3 stale error bit cleared before the cycle
        stat_reg = stat_reg | 32'h0000_0008;
        do_req(0, 3'd4, 8'h00, 8'h20, 8'h34, 0, "R3 stale status cleared");
        check(stat_reg == (stat_reg & RSV), "R3 clear kept only reserved", stat_reg, stat_reg & RSV);

        // R11 device 0 function 0
        do_req(0, 3'd4, 8'h00, 8'h00, 8'h3C, 0, "R11 device 0 read");
        check(last_addr == 32'h8000_003C, "R11 devfn 0 forwarded", last_addr, 32'h8000_003C);

        check(sb_q.size() == 0, "R10 one done per request", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule